// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the bus-facing register file of a synchronous serial port. A processor reaches it through a simple word-addressed read/write port. Behind the register file sit two eight-entry circular queues: one holds words waiting to be shifted out and one holds words that have been shifted in. A separate shift engine drains the outbound queue and fills the inbound queue through a dedicated side port. The unit also keeps the configuration registers that the engine reads.

Writing the data register appends a word to the outbound queue. Reading it removes the oldest inbound word. The status flags and the level-driven interrupt sources are derived directly from the two fill levels, so they always match the queue contents after any access. Two sticky event bits, overrun and timeout, are raised by the engine and cleared by software. A single interrupt line combines the raw sources with a software mask.

Top module: `ssp_reg_unit`

## Requirements
- R1: After reset both queues are empty, control 0, control 1 and the mask read 0, status (0x0C) reads 0x03, raw interrupt status (0x18) reads 0x08, and `irq` is low.
- R2: Status at 0x0C: bit 0 = outbound queue empty, bit 1 = outbound not full, bit 2 = inbound not empty, bit 3 = inbound full (8 entries), bit 4 = busy, set whenever the outbound queue holds any entry.
- R3: Raw status at 0x18: bit 3 is set while the outbound queue holds 4 or fewer entries, bit 2 while the inbound queue holds 4 or more, bit 0 is the sticky overrun flag set by `eng_overrun`, and bit 1 is the sticky timeout flag set by `eng_timeout`.
- R4: The mask register at 0x14 holds 4 bits. Masked status at 0x1C reads raw AND mask, and `irq` is high exactly when that AND is nonzero.
- R5: A write to 0x08 stores the data ANDed with a mask of (control0[3:0]+1) low bits in the outbound queue, in first-in first-out order. A write while the queue holds 8 entries is dropped.
- R6: A read of 0x08 returns the oldest inbound word and removes it. When the inbound queue is empty it returns 0 and changes nothing.
- R7: A write to 0x20 clears raw bit 0 and/or bit 1 wherever the written bit is 1. Bits 2 and 3 are unaffected. An engine event in the same cycle as the clear leaves the flag set.
- R8: The engine side shows the oldest outbound word on `eng_tx_data` with `eng_tx_valid`, and `eng_tx_take` removes it. `eng_rx_put` appends `eng_rx_data`, masked to the data width, while `eng_rx_room` is high; a put into a full queue is dropped. A bus access and an engine access to the same queue in one cycle both take effect.
- R9: Control 0 (0x00) holds 16 bits and control 1 (0x04) holds 4 bits; `eng_loop` is control1 bit 0 and `eng_en` is control1 bit 1. The prescaler at 0x10 keeps only its low 8 bits. The register at 0x24 always reads 0.
- R10: Addresses 0xFE0 to 0xFFC return one identification byte per word, in order: 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Unmapped offsets read 0 and ignore writes. This includes any address with nonzero low two bits and the clear register when it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during the access cycle |
| irq | output | 1 | Combined interrupt |
| eng_en | output | 1 | Port enable from control 1 |
| eng_loop | output | 1 | Loopback select from control 1 |
| eng_tx_valid | output | 1 | Outbound queue not empty |
| eng_tx_data | output | 16 | Oldest outbound word |
| eng_tx_take | input | 1 | Remove the oldest outbound word |
| eng_rx_room | output | 1 | Inbound queue not full |
| eng_rx_put | input | 1 | Append a received word |
| eng_rx_data | input | 16 | Received word |
| eng_overrun | input | 1 | Overrun event pulse |
| eng_timeout | input | 1 | Timeout event pulse |

## Verification
The bus and the shift engine can act on the same queue in the same cycle: a data-register read can coincide with an engine put, and a data-register write can coincide with an engine take. A clear-register write can also meet an overrun pulse in one cycle. The bench drives each pair in a single cycle. It then judges the result from the status flags, the order of the words that later drain, and the raw status, all checked against counts and flag values it works out independently.

// File: rtl/ssp_reg_unit.sv
module ssp_reg_unit #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          eng_en,
  output logic          eng_loop,
  output logic          eng_tx_valid,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_tx_take,
  output logic          eng_rx_room,
  input  logic          eng_rx_put,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_overrun,
  input  logic          eng_timeout
);
  localparam int DEPTH = 1 << PW;
  localparam int CW    = PW + 1;
  localparam int WW    = AW - 2;
  localparam logic [WW-1:0] W_CR0 = WW'(0);
  localparam logic [WW-1:0] W_CR1 = WW'(1);
  localparam logic [WW-1:0] W_DAT = WW'(2);
  localparam logic [WW-1:0] W_STA = WW'(3);
  localparam logic [WW-1:0] W_PRE = WW'(4);
  localparam logic [WW-1:0] W_MSK = WW'(5);
  localparam logic [WW-1:0] W_RAW = WW'(6);
  localparam logic [WW-1:0] W_MIS = WW'(7);
  localparam logic [WW-1:0] W_CLR = WW'(8);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF  = CW'(DEPTH / 2);

  logic [15:0]   cr0;
  logic [3:0]    cr1;
  logic [7:0]    pre;
  logic [3:0]    msk;
  logic          ovr_q, tmo_q;
  logic [DW-1:0] txm [DEPTH];
  logic [DW-1:0] rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire [WW-1:0] widx    = bus_addr[AW-1:2];
  wire          aligned = bus_addr[1:0] == 2'b00;
  wire          wr      = bus_sel && bus_wr && aligned;
  wire          rd      = bus_sel && !bus_wr && aligned;
  wire          is_id   = &widx[WW-1:3];

  wire [31:0]   m32   = (32'd2 << cr0[3:0]) - 32'd1;
  wire [DW-1:0] dmask = m32[DW-1:0];

  wire tx_push = wr && widx == W_DAT && tx_cnt != FULL;
  wire tx_pop  = eng_tx_take && tx_cnt != '0;
  wire rx_push = eng_rx_put && rx_cnt != FULL;
  wire rx_pop  = rd && widx == W_DAT && rx_cnt != '0;

  wire [4:0] sta = {tx_cnt != '0, rx_cnt == FULL, rx_cnt != '0, tx_cnt != FULL, tx_cnt == '0};
  wire [3:0] raw = {tx_cnt <= HALF, rx_cnt >= HALF, tmo_q, ovr_q};

  assign irq          = |(raw & msk);
  assign eng_en       = cr1[1];
  assign eng_loop     = cr1[0];
  assign eng_tx_valid = tx_cnt != '0;
  assign eng_tx_data  = txm[tx_rp];
  assign eng_rx_room  = rx_cnt != FULL;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = 8'h22;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (is_id) bus_rdata = DW'(id_byte(widx[2:0]));
      else begin
        case (widx)
          W_CR0: bus_rdata = DW'(cr0);
          W_CR1: bus_rdata = DW'(cr1);
          W_DAT: bus_rdata = (rx_cnt != '0) ? rxm[rx_rp] : '0;
          W_STA: bus_rdata = DW'(sta);
          W_PRE: bus_rdata = DW'(pre);
          W_MSK: bus_rdata = DW'(msk);
          W_RAW: bus_rdata = DW'(raw);
          W_MIS: bus_rdata = DW'(raw & msk);
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr0 <= '0;
      cr1 <= '0;
      pre <= '0;
      msk <= '0;
    end else if (wr) begin
      case (widx)
        W_CR0: cr0 <= bus_wdata[15:0];
        W_CR1: cr1 <= bus_wdata[3:0];
        W_PRE: pre <= bus_wdata[7:0];
        W_MSK: msk <= bus_wdata[3:0];
        default: ;
      endcase
    end
  end

  wire clr_hit = wr && widx == W_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      ovr_q <= eng_overrun || (ovr_q && !(clr_hit && bus_wdata[0]));
      tmo_q <= eng_timeout || (tmo_q && !(clr_hit && bus_wdata[1]));
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= bus_wdata & dmask;
    if (rx_push) rxm[rx_wp] <= eng_rx_data & dmask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end
endmodule

// File: rtl/ssp_reg_unit_chk.sv
module ssp_reg_unit_chk #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          irq,
  input logic          eng_tx_take,
  input logic          eng_rx_put,
  input logic          eng_overrun,
  input logic          ovr_q,
  input logic [PW:0]   tx_cnt,
  input logic [PW:0]   rx_cnt
);
  localparam int DEPTH = 1 << PW;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  wire ok_a  = bus_addr[1:0] == 2'b00;
  wire wr_dr = bus_sel && bus_wr && ok_a && bus_addr[AW-1:2] == (AW-2)'(2);
  wire rd_dr = bus_sel && !bus_wr && ok_a && bus_addr[AW-1:2] == (AW-2)'(2);
  wire rd_mk = bus_sel && !bus_wr && ok_a && bus_addr[AW-1:2] == (AW-2)'(5);
  wire wr_cl = bus_sel && bus_wr && ok_a && bus_addr[AW-1:2] == (AW-2)'(8);

  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == FULL && wr_dr && !eng_tx_take) |=> tx_cnt == FULL);

  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && rd_dr) |-> bus_rdata == '0);

  a_r6_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && rd_dr && !eng_rx_put) |=> rx_cnt == '0);

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL);

  a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != '0 && rx_cnt != FULL && rd_dr && eng_rx_put) |=> $stable(rx_cnt));

  a_r4_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mk && bus_rdata == '0) |-> !irq);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cl && bus_wdata[0] && !eng_overrun) |=> !ovr_q);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eng_overrun |=> ovr_q);
endmodule

bind ssp_reg_unit ssp_reg_unit_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .eng_tx_take(eng_tx_take), .eng_rx_put(eng_rx_put),
  .eng_overrun(eng_overrun), .ovr_q(ovr_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/sim_ssp_reg_unit.sv
module sim_ssp_reg_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, eng_en, eng_loop, eng_tx_valid, eng_rx_room;
  logic [15:0] eng_tx_data;
  logic eng_tx_take = 1'b0, eng_rx_put = 1'b0, eng_overrun = 1'b0, eng_timeout = 1'b0;
  logic [15:0] eng_rx_data = '0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssp_reg_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .eng_en(eng_en), .eng_loop(eng_loop),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_tx_take(eng_tx_take), .eng_rx_room(eng_rx_room),
    .eng_rx_put(eng_rx_put), .eng_rx_data(eng_rx_data),
    .eng_overrun(eng_overrun), .eng_timeout(eng_timeout)
  );

  // {check, write, req, addr, wdata, expected}
  localparam int NV = 28;
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd1,  12'h00C, 16'h0000, 16'h0003}, // R1 status
    {1'b1, 1'b0, 4'd1,  12'h018, 16'h0000, 16'h0008}, // R1 raw
    {1'b1, 1'b0, 4'd1,  12'h014, 16'h0000, 16'h0000}, // R1 mask
    {1'b1, 1'b0, 4'd1,  12'h000, 16'h0000, 16'h0000}, // R1 control 0
    {1'b0, 1'b1, 4'd9,  12'h000, 16'h0007, 16'h0000}, // R9 8-bit words
    {1'b1, 1'b0, 4'd9,  12'h000, 16'h0000, 16'h0007}, // R9
    {1'b0, 1'b1, 4'd9,  12'h010, 16'h1ABC, 16'h0000}, // R9 prescaler
    {1'b1, 1'b0, 4'd9,  12'h010, 16'h0000, 16'h00BC}, // R9
    {1'b0, 1'b1, 4'd9,  12'h024, 16'hFFFF, 16'h0000}, // R9 dma control
    {1'b1, 1'b0, 4'd9,  12'h024, 16'h0000, 16'h0000}, // R9
    {1'b1, 1'b0, 4'd10, 12'hFE0, 16'h0000, 16'h0022}, // R10
    {1'b1, 1'b0, 4'd10, 12'hFE4, 16'h0000, 16'h0010}, // R10
    {1'b1, 1'b0, 4'd10, 12'hFF0, 16'h0000, 16'h000D}, // R10
    {1'b1, 1'b0, 4'd10, 12'hFFC, 16'h0000, 16'h00B1}, // R10
    {1'b0, 1'b1, 4'd9,  12'h004, 16'hFFFF, 16'h0000}, // R9 control 1
    {1'b1, 1'b0, 4'd9,  12'h004, 16'h0000, 16'h000F}, // R9
    {1'b0, 1'b1, 4'd11, 12'h040, 16'hFFFF, 16'h0000}, // R11 unmapped
    {1'b1, 1'b0, 4'd11, 12'h040, 16'h0000, 16'h0000}, // R11
    {1'b0, 1'b1, 4'd11, 12'h002, 16'hFFFF, 16'h0000}, // R11 unaligned
    {1'b1, 1'b0, 4'd11, 12'h000, 16'h0000, 16'h0007}, // R11 control 0 kept
    {1'b0, 1'b1, 4'd5,  12'h008, 16'h1234, 16'h0000}, // R5 push
    {1'b1, 1'b0, 4'd2,  12'h00C, 16'h0000, 16'h0012}, // R2 busy, not full
    {1'b1, 1'b0, 4'd3,  12'h018, 16'h0000, 16'h0008}, // R3
    {1'b0, 1'b1, 4'd4,  12'h014, 16'hFFFF, 16'h0000}, // R4
    {1'b1, 1'b0, 4'd4,  12'h014, 16'h0000, 16'h000F}, // R4 4-bit mask
    {1'b1, 1'b0, 4'd4,  12'h01C, 16'h0000, 16'h0008}, // R4 masked
    {1'b0, 1'b1, 4'd4,  12'h014, 16'h0008, 16'h0000}, // R4
    {1'b1, 1'b0, 4'd11, 12'h020, 16'h0000, 16'h0000}  // R11 clear reads 0
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a rising edge; drives one cycle and samples in the low phase.
  task automatic cyc(input logic sel, we, input logic [11:0] a, input logic [15:0] wd,
                     input logic take, put, input logic [15:0] pd, input logic ovr, tmo,
                     output logic [15:0] rd);
    bus_sel = sel; bus_wr = we; bus_addr = a; bus_wdata = wd;
    eng_tx_take = take; eng_rx_put = put; eng_rx_data = pd;
    eng_overrun = ovr; eng_timeout = tmo;
    @(negedge clk); #2;
    rd = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; eng_tx_take = 1'b0; eng_rx_put = 1'b0;
    eng_overrun = 1'b0; eng_timeout = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    logic [15:0] r;
    cyc(1, 1, a, d, 0, 0, 0, 0, 0, r);
  endtask
  task automatic rd(input logic [11:0] a, output logic [15:0] r);
    cyc(1, 0, a, 0, 0, 0, 0, 0, 0, r);
  endtask
  task automatic take();
    logic [15:0] r;
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, r);
  endtask
  task automatic put(input logic [15:0] d);
    logic [15:0] r;
    cyc(0, 0, 0, 0, 0, 1, d, 0, 0, r);
  endtask
  task automatic pulse(input logic o, t);
    logic [15:0] r;
    cyc(0, 0, 0, 0, 0, 0, 0, o, t, r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 tx_valid", {15'd0, eng_tx_valid}, 16'd0);
    chk("R1 rx_room", {15'd0, eng_rx_room}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      cyc(1, v[48], v[43:32], v[31:16], 0, 0, 0, 0, 0, r);
      if (v[49]) chk($sformatf("R%0d vec%0d", v[47:44], i), r, v[15:0]);
    end
    chk("R9 eng_en/loop", {14'd0, eng_en, eng_loop}, 16'h0003);
    chk("R4 irq on", {15'd0, irq}, 16'd1);

    // R5 R8: masked word visible on engine side
    chk("R8 tx_valid", {15'd0, eng_tx_valid}, 16'd1);
    chk("R5 masked data", eng_tx_data, 16'h0034);
    take();
    chk("R8 drained", {15'd0, eng_tx_valid}, 16'd0);

    // R5: fill to 8, ninth dropped
    for (int i = 0; i < 8; i++) wr(12'h008, 16'h00A0 + 16'(i));
    wr(12'h008, 16'h00EE);
    rd(12'h00C, r); chk("R2 tx full status", r, 16'h0010);
    rd(12'h018, r); chk("R3 tx level 8", r, 16'h0000);
    chk("R4 irq off", {15'd0, irq}, 16'd0);
    for (int i = 0; i < 3; i++) begin
      chk("R5 order", eng_tx_data, 16'h00A0 + 16'(i));
      take();
    end
    rd(12'h018, r); chk("R3 tx level 5", r, 16'h0000);
    take();
    rd(12'h018, r); chk("R3 tx level 4", r, 16'h0008);
    for (int i = 4; i < 8; i++) begin
      chk("R5 order", eng_tx_data, 16'h00A0 + 16'(i));
      take();
    end
    chk("R5 ninth dropped", {15'd0, eng_tx_valid}, 16'd0);

    // R8: bus write and engine take in the same cycle
    wr(12'h008, 16'h0011);
    cyc(1, 1, 12'h008, 16'h0022, 1, 0, 0, 0, 0, r);
    chk("R8 tx same-cycle", eng_tx_data, 16'h0022);
    take();
    chk("R8 tx same-cycle empty", {15'd0, eng_tx_valid}, 16'd0);

    // R6 R8: inbound fill, overflow, drain
    for (int i = 0; i < 8; i++) put(16'h1230 + 16'(i));
    chk("R8 rx_room full", {15'd0, eng_rx_room}, 16'd0);
    put(16'h0099);
    rd(12'h00C, r); chk("R2 rx full status", r, 16'h000F);
    rd(12'h018, r); chk("R3 rx level 8", r, 16'h000C);
    for (int i = 0; i < 4; i++) begin
      rd(12'h008, r); chk("R6 rx order", r, 16'h0030 + 16'(i));
    end
    rd(12'h018, r); chk("R3 rx level 4", r, 16'h000C);
    rd(12'h008, r); chk("R6 rx order", r, 16'h0034);
    rd(12'h018, r); chk("R3 rx level 3", r, 16'h0008);
    for (int i = 5; i < 8; i++) begin
      rd(12'h008, r); chk("R6 rx order", r, 16'h0030 + 16'(i));
    end
    rd(12'h008, r); chk("R6 empty read", r, 16'h0000);
    rd(12'h00C, r); chk("R6 empty unchanged", r, 16'h0003);

    // R8: bus read and engine put in the same cycle
    put(16'h0041); put(16'h0042);
    cyc(1, 0, 12'h008, 0, 0, 1, 16'h0043, 0, 0, r);
    chk("R8 rx same-cycle data", r, 16'h0041);
    rd(12'h008, r); chk("R8 rx same-cycle 2nd", r, 16'h0042);
    rd(12'h00C, r); chk("R8 rx one left", r, 16'h0007);
    rd(12'h008, r); chk("R8 rx same-cycle 3rd", r, 16'h0043);
    rd(12'h008, r); chk("R8 rx now empty", r, 16'h0000);

    // R3 R7: sticky flags
    pulse(1, 0);
    rd(12'h018, r); chk("R3 overrun set", r, 16'h0009);
    pulse(0, 1);
    rd(12'h018, r); chk("R3 timeout set", r, 16'h000B);
    wr(12'h020, 16'h000C);
    rd(12'h018, r); chk("R7 level bits not cleared", r, 16'h000B);
    wr(12'h020, 16'h0001);
    rd(12'h018, r); chk("R7 clear overrun", r, 16'h000A);
    wr(12'h020, 16'h0002);
    rd(12'h018, r); chk("R7 clear timeout", r, 16'h0008);
    cyc(1, 1, 12'h020, 16'h0001, 0, 0, 0, 1, 0, r);
    rd(12'h018, r); chk("R7 set wins", r, 16'h0009);
    wr(12'h020, 16'h0003);

    // R4: mask selects sources
    wr(12'h014, 16'h0001);
    chk("R4 masked out", {15'd0, irq}, 16'd0);
    pulse(1, 0);
    chk("R4 overrun irq", {15'd0, irq}, 16'd1);
    rd(12'h01C, r); chk("R4 masked status", r, 16'h0001);
    wr(12'h014, 16'h0000);
    chk("R4 mask zero", {15'd0, irq}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule